// File: doc/BRIEF.md
# Coded Interval Timer

This block is a free-running periodic timer that raises an interrupt request at a fixed interval. The interval is not given as a raw cycle count. A 4-bit select code picks one of sixteen periods, and each period is a whole multiple of 64 instruction cycles. The mapping is inverted: the smallest code gives the longest interval and the largest code gives the shortest. Time advances only on clock cycles where the instruction-cycle enable is high. A separate run enable can freeze the count without losing its position.

When the interval runs out, the timer raises a request for a downstream interrupt controller, which latches it into its timer request flag. The timer then reloads itself and starts the next interval with no gap. Loading a new code restarts the interval at once, using the full period of that code. The request output is registered. It stays high until the controller has seen it at exactly one enabled cycle, so a controller that samples only on enabled cycles cannot miss it and cannot count it twice.

Top module: `coded_interval_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, the request output is low. Reset selects code 0, so the first request comes after 1024 enabled counting cycles.
- R2: Code n, read as an unsigned 4-bit value, sets a period of (16 − n) × 64 counting cycles. Code 0 gives 1024 cycles and code 15 gives 64. At a 100 kHz instruction rate these are 10.24 ms and 0.64 ms.
- R3: After a request, the timer reloads the period of the current code and keeps running. Requests repeat every period with no extra cycles between intervals.
- R4: The count advances only on clock edges where the instruction-cycle enable is high. Edges with the enable low leave the count and the request output unchanged.
- R5: The request rises on the clock cycle after the edge that completes a period. It stays high up to and including the next edge at which the instruction-cycle enable is high, and falls after that edge. It is therefore seen high at exactly one enabled edge per expiry.
- R6: While the run enable is low, the count holds its value and no new request is raised. Counting resumes from that held value when the run enable returns high.
- R7: A load strobe stores the presented code and restarts the count at the full period of that code. This holds whatever the levels of the run enable and the instruction-cycle enable.
- R8: When a load strobe arrives on the same edge that would complete a period, the load wins. No request is raised for that expiry, and the next request follows one full period of the newly loaded code later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable; one pulse per counted cycle |
| run_en | input | 1 | Allows counting when high |
| code_load | input | 1 | Strobe that stores `code_in` and restarts the interval |
| code_in | input | 4 | Period select code |
| irq_req | output | 1 | Registered interrupt request |

## Verification
Two events can land on the same edge: the expiry of a period and a code load. The bench provokes this by counting 63 enabled cycles under code 15 and then presenting a load strobe on the 64th enabled edge. It judges the result by requiring that no request appears after that edge, and that the next request comes exactly 64 enabled edges after the load. A second case checks the end of a request against the enable. The enable is thinned to one edge in three, and the bench confirms that the request stays high across the disabled edges and falls only after the first enabled one.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // default geometry of the timer
  localparam int unsigned IVT_CODE_W = 4;
  localparam int unsigned IVT_STEP   = 64;

  // bits needed to hold the longest period, (2**code_w) * step
  function automatic int unsigned ivt_cnt_width(input int unsigned code_w,
                                                input int unsigned step);
    return $clog2(((1 << code_w) * step) + 1);
  endfunction
endpackage

// File: rtl/ivt_span.sv
// Expands a select code into its period length: (2**CODE_W - code) * STEP
module ivt_span #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STEP   = 64,
  parameter int unsigned CNT_W  = 11
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  span
);
  localparam int unsigned SHIFT = $clog2(STEP);
  localparam bit STEP_POW2 = ((STEP & (STEP - 1)) == 0);

  logic [CODE_W:0] mult;
  assign mult = (CODE_W + 1)'(1 << CODE_W) - {1'b0, code};

  generate
    if (STEP_POW2) begin : g_shift
      assign span = CNT_W'(mult) << SHIFT;
    end else begin : g_mul
      assign span = CNT_W'(mult) * CNT_W'(STEP);
    end
  endgenerate
endmodule

// File: rtl/ivt_code_reg.sv
// Holds the active select code; reset selects the longest period
module ivt_code_reg #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (load) begin
      code_q <= code_in;
    end
  end
endmodule

// File: rtl/ivt_countdown.sv
// Remaining-cycle counter; a load has priority over counting
module ivt_countdown #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [CNT_W-1:0] load_span,
  input  logic [CNT_W-1:0] reload_span,
  input  logic [CNT_W-1:0] reset_span,
  output logic             expire
);
  logic [CNT_W-1:0] left_q;
  logic             last_cycle;

  assign last_cycle = (left_q == CNT_W'(1));
  assign expire     = advance && !load && last_cycle;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= reset_span;
    end else if (load) begin
      left_q <= load_span;
    end else if (advance) begin
      if (last_cycle) begin
        left_q <= reload_span;
      end else begin
        left_q <= left_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ivt_req_hold.sv
// Registered request: set on expiry, cleared after the next enabled edge
module ivt_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic cyc_en,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
    end else if (expire) begin
      req <= 1'b1;
    end else if (cyc_en) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/coded_interval_timer.sv
module coded_interval_timer #(
  parameter int unsigned CODE_W = ivt_pkg::IVT_CODE_W,
  parameter int unsigned STEP   = ivt_pkg::IVT_STEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic              run_en,
  input  logic              code_load,
  input  logic [CODE_W-1:0] code_in,
  output logic              irq_req
);
  localparam int unsigned CNT_W = ivt_pkg::ivt_cnt_width(CODE_W, STEP);

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  span_new;
  logic [CNT_W-1:0]  span_cur;
  logic [CNT_W-1:0]  span_rst;
  logic              advance;
  logic              expire;

  assign advance = cyc_en && run_en;

  ivt_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst     (rst),
    .load    (code_load),
    .code_in (code_in),
    .code_q  (code_q)
  );

  ivt_span #(.CODE_W(CODE_W), .STEP(STEP), .CNT_W(CNT_W)) u_span_new (
    .code (code_in),
    .span (span_new)
  );

  ivt_span #(.CODE_W(CODE_W), .STEP(STEP), .CNT_W(CNT_W)) u_span_cur (
    .code (code_q),
    .span (span_cur)
  );

  ivt_span #(.CODE_W(CODE_W), .STEP(STEP), .CNT_W(CNT_W)) u_span_rst (
    .code ('0),
    .span (span_rst)
  );

  ivt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .load        (code_load),
    .advance     (advance),
    .load_span   (span_new),
    .reload_span (span_cur),
    .reset_span  (span_rst),
    .expire      (expire)
  );

  ivt_req_hold u_req (
    .clk    (clk),
    .rst    (rst),
    .expire (expire),
    .cyc_en (cyc_en),
    .req    (irq_req)
  );
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STEP   = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_en,
  input logic              run_en,
  input logic              code_load,
  input logic [CODE_W-1:0] code_in,
  input logic              irq_req
);
  // port-level tracking of the selected code and of counted edges
  int unsigned       gap;
  logic [CODE_W-1:0] seen_code;
  logic              req_d;
  logic              rise;
  int unsigned       want;

  assign rise = irq_req && !req_d;
  assign want = ((1 << CODE_W) - int'(seen_code)) * STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= 0;
      seen_code <= '0;
      req_d     <= 1'b0;
    end else begin
      req_d <= irq_req;
      if (code_load) begin
        gap       <= 0;
        seen_code <= code_in;
      end else begin
        gap <= (rise ? 0 : gap) + ((cyc_en && run_en) ? 1 : 0);
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !irq_req);

  // R2 R3
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> (gap == want));

  // R4
  idle_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> !$rose(irq_req));

  // R5
  single_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && cyc_en) |=> !irq_req);

  // R5
  fall_on_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_req) |-> $past(cyc_en));

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !$rose(irq_req));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    code_load |=> !$rose(irq_req));
endmodule

bind coded_interval_timer ivt_checker #(.CODE_W(CODE_W), .STEP(STEP)) u_ivt_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_en    (cyc_en),
  .run_en    (run_en),
  .code_load (code_load),
  .code_in   (code_in),
  .irq_req   (irq_req)
);

// File: tb/coded_interval_timer_test.sv
module coded_interval_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       run_en = 1'b0;
  logic       code_load = 1'b0;
  logic [3:0] code_in = 4'd0;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state, built from the requirements
  int period_now = 1024;
  int counted    = 0;
  bit exp_req    = 1'b0;

  coded_interval_timer uut (
    .clk       (clk),
    .rst       (rst),
    .cyc_en    (cyc_en),
    .run_en    (run_en),
    .code_load (code_load),
    .code_in   (code_in),
    .irq_req   (irq_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int span_of(input int c);
    return (16 - c) * 64;
  endfunction

  task automatic check(input bit got, input bit want, input string req);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: irq_req=%0b expected %0b at %0t", req, got, want, $time);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, sample at next negedge
  task automatic tick(input bit en, input bit run, input bit ld,
                      input int c, input string req);
    cyc_en    = en;
    run_en    = run;
    code_load = ld;
    code_in   = 4'(c);
    @(posedge clk);
    if (ld) begin
      period_now = span_of(c);
      counted    = 0;
      if (en) exp_req = 1'b0;
    end else begin
      if (en) exp_req = 1'b0;
      if (en && run) begin
        counted++;
        if (counted == period_now) begin
          counted = 0;
          exp_req = 1'b1;
        end
      end
    end
    @(negedge clk);
    code_load = 1'b0;
    check(irq_req, exp_req, req);
  endtask

  task automatic run_ticks(input int n, input bit run, input string req);
    for (int i = 0; i < n; i++) tick(1'b1, run, 1'b0, 0, req);
  endtask

  // R1 R2: reset state and default longest period of 1024
  task automatic t_reset_default();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_req, 1'b0, "R1");
    rst = 1'b0;
    period_now = 1024; counted = 0; exp_req = 1'b0;
    tick(1'b1, 1'b1, 1'b0, 0, "R1");
    run_ticks(1030, 1'b1, "R2");
  endtask

  // R2 R3: shortest code repeats, then a mid code
  task automatic t_codes_repeat();
    tick(1'b1, 1'b1, 1'b1, 15, "R7");
    run_ticks(200, 1'b1, "R3");
    tick(1'b1, 1'b1, 1'b1, 7, "R7");
    run_ticks(580, 1'b1, "R2");
  endtask

  // R4 R5: enable on one edge in three
  task automatic t_sparse_enable();
    tick(1'b1, 1'b1, 1'b1, 14, "R7");
    for (int i = 1; i < 3 * 270; i++) tick((i % 3) == 0, 1'b1, 1'b0, 0, "R5");
  endtask

  // R6: run low freezes the count
  task automatic t_pause();
    tick(1'b1, 1'b1, 1'b1, 15, "R7");
    run_ticks(30, 1'b1, "R6");
    run_ticks(150, 1'b0, "R6");
    run_ticks(110, 1'b1, "R6");
  endtask

  // R7: reload mid-count restarts with the new period
  task automatic t_reload_mid();
    tick(1'b1, 1'b1, 1'b1, 15, "R7");
    run_ticks(40, 1'b1, "R7");
    tick(1'b1, 1'b1, 1'b1, 13, "R7");
    run_ticks(200, 1'b1, "R7");
  endtask

  // R8: load on the expiring edge wins, no request
  task automatic t_load_at_expiry();
    tick(1'b1, 1'b1, 1'b1, 15, "R7");
    run_ticks(63, 1'b1, "R8");
    tick(1'b1, 1'b1, 1'b1, 15, "R8");
    check(irq_req, 1'b0, "R8");
    run_ticks(63, 1'b1, "R8");
    check(irq_req, 1'b0, "R8");
    tick(1'b1, 1'b1, 1'b0, 0, "R8");
    check(irq_req, 1'b1, "R8");
    run_ticks(5, 1'b1, "R8");
  endtask

  // R7: load with both enables low still takes effect
  task automatic t_load_idle();
    run_ticks(20, 1'b1, "R7");
    tick(1'b0, 1'b0, 1'b1, 15, "R7");
    run_ticks(70, 1'b1, "R7");
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset_default();
        t_codes_repeat();
        t_sparse_enable();
        t_pause();
        t_reload_mid();
        t_load_at_expiry();
        t_load_idle();
        done = 1'b1;
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: run did not complete, expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule